// File: doc/BRIEF.md
# I2C Multi-Address Matcher with Reset Call

This block sits behind the bit-level front end of an I2C target. The front end reports START and STOP events and each received byte. A flag marks the first byte after a START. For every byte the matcher returns a registered acknowledge decision one clock later.

For the address byte, the matcher compares the upper seven bits with several addresses:
- a hardware address taken from pins;
- one broadcast (all-call) address;
- three alias (sub-call) addresses.

Each programmable address has its own enable bit. A small local configuration port writes and reads these addresses and enables.

The matcher also watches for the reset call. This is the address byte 06h followed by an exact two-byte key, A5h then 5Ah. It emits a one-cycle reset pulse only when a STOP ends a sequence that had no errors. The same event restores the matcher's own address and enable registers to their power-up values. The reset pulse is meant to fan out to the register file and other state of the device.

Top module: `i2c_alias_matcher`

## Requirements
- R1: For each received byte (`rx_vld` high for one cycle), `ack_vld` is high in the next cycle with the decision on `ack_out`. A first byte whose bits [7:1] equal `hw_addr` is acknowledged whether bit 0 (1 = read, 0 = write) is 0 or 1.
- R2: After reset the broadcast address is 1110000 and enabled, so address bytes E0h and E1h are acknowledged.
- R3: Enable register fields are: bit 0 broadcast, bits 1..3 aliases 1..3, and bits 7:4 read 0. `cfg_sel` selects 0 = enables, 1 = broadcast address, 2..4 = aliases 1..3. The aliases reset to 1110001, 1110010 and 1110100 and are disabled. Each alias is acknowledged for read and write only while its enable bit is 1.
- R4: Address registers keep `cfg_wdata[7:1]`. Their read-back has bit 0 equal to 0 whatever was written.
- R5: `addr_match` goes high in the cycle after an acknowledged address byte that hits a normal address, and it clears after any START or STOP. Data bytes are acknowledged while matched and not acknowledged otherwise. An address byte that hits several addresses still gives a single acknowledge.
- R6: Address byte 06h is acknowledged and 07h is not. After 06h, the first data byte is acknowledged only if it is A5h, and the second only if it is 5Ah.
- R7: In a reset call, every byte after the two key bytes is not acknowledged.
- R8: `srst_pulse` is high for exactly one cycle, in the cycle after a STOP that follows 06h, A5h, 5Ah and no other byte. A wrong key byte, an extra byte, or a START before the STOP gives no pulse.
- R9: In the cycle of `srst_pulse`, the configuration read-back already shows the reset values: enables 01h, broadcast E0h, aliases E2h, E4h, E8h.
- R10: A broadcast address whose enable bit is 0 is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_addr | input | 7 | Pin-strapped device address |
| ev_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| ev_stop | input | 1 | STOP seen (one-cycle pulse) |
| rx_vld | input | 1 | A received byte is presented (one-cycle pulse) |
| rx_first | input | 1 | The presented byte is the first after START |
| rx_data | input | 8 | Received byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (3) | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back of the selected register |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_out | output | 1 | Acknowledge decision (1 = ACK) |
| addr_match | output | 1 | Device currently addressed through a normal address |
| srst_pulse | output | 1 | One-cycle reset command |

## Verification
A wrong comparison or a wrong enable shows on `ack_out` one cycle after the address byte. A lost or stale match flag shows on the acknowledge of the very next data byte.

A key-sequence state that has advanced wrongly appears as a wrong acknowledge on the following key byte. If it has failed to abort, the result is a reset pulse in the cycle after STOP where none belongs.

Configuration that was not cleared is visible on `cfg_rdata` in the pulse cycle itself. The bench sweeps all 256 address bytes under three enable and address settings. It then drives complete, broken and interrupted reset calls.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int ADDR_W = 7;
  typedef logic [ADDR_W-1:0] addr7_t;

  typedef enum logic [2:0] {
    KS_IDLE,
    KS_ADDR,
    KS_KEY1,
    KS_ARMED,
    KS_DEAD
  } key_state_e;

  localparam addr7_t BCAST_DEFAULT = 7'h70;
  localparam addr7_t SRST_ADDR     = 7'h03;
  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  // alias k defaults to 1110000 with bit k set
  function automatic addr7_t alias_default(input int k);
    return BCAST_DEFAULT | addr7_t'(1 << k);
  endfunction

  // upper seven bits of an address byte against a stored address
  function automatic logic addr_eq(input logic [7:0] b, input addr7_t a);
    return b[7:1] == a;
  endfunction

  function automatic logic [7:0] addr_readback(input addr7_t a);
    return {a, 1'b0};
  endfunction
endpackage

// File: rtl/i2cm_alias_regs.sv
module i2cm_alias_regs
  import i2cm_pkg::*;
#(
  parameter int NUM_SUB = 3,
  localparam int SEL_W = $clog2(NUM_SUB + 2),
  localparam int EN_W  = NUM_SUB + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        cfg_we,
  input  logic [SEL_W-1:0]            cfg_sel,
  input  logic [7:0]                  cfg_wdata,
  output logic [EN_W-1:0]             en_o,
  output addr7_t                      bcast_o,
  output logic [NUM_SUB-1:0][ADDR_W-1:0] sub_o,
  output logic [7:0]                  cfg_rdata
);
  localparam logic [EN_W-1:0] EN_DEFAULT = EN_W'(1);

  logic [EN_W-1:0] en_q;
  addr7_t          bcast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= EN_DEFAULT;
      bcast_q <= BCAST_DEFAULT;
    end else if (clear) begin
      en_q    <= EN_DEFAULT;
      bcast_q <= BCAST_DEFAULT;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_W'(0)) en_q    <= cfg_wdata[EN_W-1:0];
      if (cfg_sel == SEL_W'(1)) bcast_q <= cfg_wdata[7:1];
    end
  end

  for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
    localparam addr7_t SUB_DEF = alias_default(k);
    addr7_t sub_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   sub_q <= SUB_DEF;
      else if (clear)                               sub_q <= SUB_DEF;
      else if (cfg_we && cfg_sel == SEL_W'(k + 2))  sub_q <= cfg_wdata[7:1];
    end
    assign sub_o[k] = sub_q;
  end

  assign en_o    = en_q;
  assign bcast_o = bcast_q;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel == SEL_W'(0)) cfg_rdata[EN_W-1:0] = en_q;
    if (cfg_sel == SEL_W'(1)) cfg_rdata = addr_readback(bcast_q);
    for (int k = 0; k < NUM_SUB; k++)
      if (cfg_sel == SEL_W'(k + 2)) cfg_rdata = addr_readback(sub_o[k]);
  end

  // R9: a clear leaves every field at its power-up value
  assert_clear_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (en_o == EN_DEFAULT && bcast_o == BCAST_DEFAULT));

  // R4: address read-back never shows a set low bit
  assert_lsb_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel != SEL_W'(0)) |-> !cfg_rdata[0]);
endmodule

// File: rtl/i2cm_addr_decode.sv
module i2cm_addr_decode
  import i2cm_pkg::*;
#(
  parameter int NUM_SUB = 3,
  localparam int EN_W = NUM_SUB + 1
) (
  input  logic [7:0]                     rx_data,
  input  addr7_t                         hw_addr,
  input  logic [EN_W-1:0]                en,
  input  addr7_t                         bcast,
  input  logic [NUM_SUB-1:0][ADDR_W-1:0] sub,
  output logic                           hit_any,
  output logic                           is_srst
);
  logic                hit_hw;
  logic                hit_bcast;
  logic [NUM_SUB-1:0]  hit_sub;

  assign hit_hw    = addr_eq(rx_data, hw_addr);
  assign hit_bcast = en[0] & addr_eq(rx_data, bcast);

  for (genvar k = 0; k < NUM_SUB; k++) begin : g_hit
    assign hit_sub[k] = en[k+1] & addr_eq(rx_data, sub[k]);
  end

  assign hit_any = hit_hw | hit_bcast | (|hit_sub);
  // reset call only with the write direction
  assign is_srst = addr_eq(rx_data, SRST_ADDR) & ~rx_data[0];
endmodule

// File: rtl/i2cm_key_fsm.sv
module i2cm_key_fsm
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       byte_ev,
  input  logic       rx_first,
  input  logic [7:0] rx_data,
  input  logic       is_srst,
  output logic       key_active,
  output logic       key_ack,
  output logic       srst_fire
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ev_start || ev_stop) begin
      state_d = KS_IDLE;
    end else if (byte_ev && rx_first) begin
      state_d = is_srst ? KS_ADDR : KS_IDLE;
    end else if (byte_ev) begin
      unique case (state_q)
        KS_ADDR:  state_d = (rx_data == KEY_FIRST)  ? KS_KEY1  : KS_DEAD;
        KS_KEY1:  state_d = (rx_data == KEY_SECOND) ? KS_ARMED : KS_DEAD;
        KS_ARMED: state_d = KS_DEAD;
        KS_DEAD:  state_d = KS_DEAD;
        default:  state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  assign key_active = (state_q != KS_IDLE);
  assign key_ack    = byte_ev && !rx_first &&
                      ((state_q == KS_ADDR && rx_data == KEY_FIRST) ||
                       (state_q == KS_KEY1 && rx_data == KEY_SECOND));
  assign srst_fire  = ev_stop && (state_q == KS_ARMED);

  // R8: the armed state is reached only through the second key byte
  assert_armed_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_ARMED) |-> ($past(state_q) == KS_KEY1 || $past(state_q) == KS_ARMED));

  // R7: a byte taken in the armed state always ends in the dead state
  assert_extra_byte_dead_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_ARMED && byte_ev && !rx_first) |=> (state_q == KS_DEAD));
endmodule

// File: rtl/i2c_alias_matcher.sv
module i2c_alias_matcher
  import i2cm_pkg::*;
#(
  parameter int NUM_SUB = 3,
  localparam int SEL_W = $clog2(NUM_SUB + 2),
  localparam int EN_W  = NUM_SUB + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       hw_addr,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             rx_vld,
  input  logic             rx_first,
  input  logic [7:0]       rx_data,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic             ack_vld,
  output logic             ack_out,
  output logic             addr_match,
  output logic             srst_pulse
);
  logic                           byte_ev;
  logic [EN_W-1:0]                en;
  addr7_t                         bcast;
  logic [NUM_SUB-1:0][ADDR_W-1:0] sub;
  logic                           hit_any;
  logic                           is_srst;
  logic                           key_active;
  logic                           key_ack;
  logic                           srst_fire;
  logic                           ack_d;

  // bus events take priority over a byte in the same cycle
  assign byte_ev = rx_vld & ~ev_start & ~ev_stop;

  i2cm_alias_regs #(.NUM_SUB(NUM_SUB)) u_regs (
    .clk(clk), .rst_n(rst_n), .clear(srst_fire),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .en_o(en), .bcast_o(bcast), .sub_o(sub), .cfg_rdata(cfg_rdata)
  );

  i2cm_addr_decode #(.NUM_SUB(NUM_SUB)) u_dec (
    .rx_data(rx_data), .hw_addr(hw_addr), .en(en), .bcast(bcast),
    .sub(sub), .hit_any(hit_any), .is_srst(is_srst)
  );

  i2cm_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .byte_ev(byte_ev), .rx_first(rx_first), .rx_data(rx_data),
    .is_srst(is_srst), .key_active(key_active), .key_ack(key_ack),
    .srst_fire(srst_fire)
  );

  always_comb begin
    if (rx_first)        ack_d = hit_any | is_srst;
    else if (key_active) ack_d = key_ack;
    else                 ack_d = addr_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld    <= 1'b0;
      ack_out    <= 1'b0;
      addr_match <= 1'b0;
      srst_pulse <= 1'b0;
    end else begin
      ack_vld    <= byte_ev;
      ack_out    <= byte_ev & ack_d;
      srst_pulse <= srst_fire;
      if (ev_start || ev_stop)     addr_match <= 1'b0;
      else if (byte_ev && rx_first) addr_match <= hit_any;
    end
  end

  // R1: a decision appears only in the cycle after a byte
  assert_ack_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(rx_vld));
  assert_ack_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> ack_vld);
  // R5: bus events drop the match
  assert_match_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> !addr_match);
  // R8: single-cycle pulse, only after a STOP
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> !srst_pulse);
  assert_pulse_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |-> $past(ev_stop));
endmodule

// File: tb/sim_i2c_alias_matcher.sv
module sim_i2c_alias_matcher;
  localparam logic [6:0] HW = 7'h2A;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ev_start = 0, ev_stop = 0, rx_vld = 0, rx_first = 0;
  logic [7:0] rx_data = 0;
  logic       cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic       ack_vld, ack_out, addr_match, srst_pulse;

  int total = 0;
  int bad = 0;

  // bench-side model of the configuration
  logic [3:0] m_en;
  logic [6:0] m_bc;
  logic [6:0] m_sub [3];

  always #2.5 clk = ~clk;

  i2c_alias_matcher u0 (
    .clk(clk), .rst_n(rst_n), .hw_addr(HW),
    .ev_start(ev_start), .ev_stop(ev_stop), .rx_vld(rx_vld),
    .rx_first(rx_first), .rx_data(rx_data), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ack_vld(ack_vld), .ack_out(ack_out), .addr_match(addr_match),
    .srst_pulse(srst_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [7:0] b);
    logic h;
    h = (b[7:1] == HW) || (m_en[0] && b[7:1] == m_bc);
    for (int k = 0; k < 3; k++) h = h || (m_en[k+1] && b[7:1] == m_sub[k]);
    return h;
  endfunction

  task automatic set_defaults();
    m_en = 4'b0001; m_bc = 7'h70;
    m_sub[0] = 7'h71; m_sub[1] = 7'h72; m_sub[2] = 7'h74;
  endtask

  task automatic do_start();
    @(negedge clk) ev_start = 1;
    @(negedge clk) ev_start = 0;
  endtask

  task automatic do_stop(output logic p);
    @(negedge clk) ev_stop = 1;
    @(negedge clk) ev_stop = 0;
    p = srst_pulse;
  endtask

  task automatic send(input logic [7:0] b, input logic first, output logic a, output logic v);
    @(negedge clk) begin rx_vld = 1; rx_first = first; rx_data = b; end
    @(negedge clk) begin rx_vld = 0; rx_first = 0; end
    a = ack_out; v = ack_vld;
  endtask

  task automatic cfg_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk) begin cfg_we = 1; cfg_sel = s; cfg_wdata = d; end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic check_cfg(input string req);
    cfg_sel = 0; #1 chk(req, cfg_rdata, {4'b0, m_en});
    cfg_sel = 1; #1 chk(req, cfg_rdata, {m_bc, 1'b0});
    for (int k = 0; k < 3; k++) begin
      cfg_sel = 3'(k + 2); #1 chk(req, cfg_rdata, {m_sub[k], 1'b0});
    end
  endtask

  task automatic sweep(input string req);
    logic a, v, p;
    for (int b = 0; b < 256; b++) begin
      do_start();
      send(8'(b), 1'b1, a, v);
      chk({req, " R1 ack_vld"}, v, 1);
      chk({req, " ack"}, a, exp_hit(8'(b)) || (b == 6));
      chk({req, " R5 match"}, addr_match, exp_hit(8'(b)));
      do_stop(p);
      chk({req, " R8 no pulse"}, p, 0);
    end
  endtask

  // reset-call attempt: address 06h then listed data bytes, then STOP or START
  task automatic key_seq(input string req, input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input int n, input logic e0,
                         input logic e1, input logic e2, input logic use_start,
                         input logic exp_pulse);
    logic a, v, p;
    do_start();
    send(8'h06, 1'b1, a, v);
    chk({req, " R6 addr 06"}, a, 1);
    if (n > 0) begin send(d0, 1'b0, a, v); chk({req, " R6 key0"}, a, e0); end
    if (n > 1) begin send(d1, 1'b0, a, v); chk({req, " R6 key1"}, a, e1); end
    if (n > 2) begin send(d2, 1'b0, a, v); chk({req, " R7 extra"}, a, e2); end
    if (use_start) do_start();
    do_stop(p);
    chk({req, " R8 pulse"}, p, exp_pulse);
    @(negedge clk) chk({req, " R8 pulse width"}, srst_pulse, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, v, p;
    set_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ack_vld", ack_vld, 0);
    chk("R8 reset pulse", srst_pulse, 0);
    chk("R5 reset match", addr_match, 0);
    check_cfg("R2 R3 reset config");

    // R2 R3: defaults, broadcast on, aliases off
    sweep("R2 R3 defaults");

    // R4: odd write data, low bit dropped
    cfg_write(1, 8'h23); m_bc = 7'h11;
    cfg_write(2, 8'h45); m_sub[0] = 7'h22;
    cfg_write(3, 8'h67); m_sub[1] = 7'h33;
    cfg_write(4, 8'h89); m_sub[2] = 7'h44;
    cfg_write(0, 8'hFA); m_en = 4'hA;
    check_cfg("R4 R3 readback");
    // R10: broadcast disabled, aliases 1 and 3 enabled
    sweep("R10 R3 partial enable");
    cfg_write(0, 8'h0F); m_en = 4'hF;
    sweep("R3 all enabled");

    // R5: data acknowledged only while matched
    do_start();
    send({HW, 1'b0}, 1'b1, a, v); chk("R5 hw addr", a, 1);
    send(8'h3C, 1'b0, a, v); chk("R5 data matched", a, 1);
    do_start();
    chk("R5 match after start", addr_match, 0);
    send(8'h56, 1'b1, a, v); chk("R5 other addr", a, 0);
    send(8'h3C, 1'b0, a, v); chk("R5 data unmatched", a, 0);
    do_stop(p);
    // R5: address hitting both alias 1 and broadcast gives one acknowledge
    cfg_write(1, 8'h44); m_bc = 7'h22;
    do_start();
    send(8'h45, 1'b1, a, v); chk("R5 double hit ack", a, 1);
    chk("R5 double hit vld", v, 1);
    @(negedge clk) chk("R5 single ack", ack_vld, 0);
    do_stop(p);

    // R6: read direction of reset address
    do_start();
    send(8'h07, 1'b1, a, v); chk("R6 07 nack", a, 0);
    send(8'hA5, 1'b0, a, v); chk("R6 key after 07", a, 0);
    do_stop(p); chk("R8 no pulse after 07", p, 0);

    key_seq("bad key0", 8'hA4, 8'h5A, 8'h00, 2, 0, 0, 0, 0, 0);
    key_seq("bad key1", 8'hA5, 8'h5B, 8'h00, 2, 1, 0, 0, 0, 0);
    key_seq("extra byte", 8'hA5, 8'h5A, 8'h00, 3, 1, 1, 0, 0, 0);
    key_seq("start mid", 8'hA5, 8'h5A, 8'h00, 2, 1, 1, 0, 1, 0);
    key_seq("short", 8'hA5, 8'h5A, 8'h00, 1, 1, 0, 0, 0, 0);
    check_cfg("R9 untouched by failed calls");

    // R8 R9: valid call, config restored in the pulse cycle
    do_start();
    send(8'h06, 1'b1, a, v); chk("R6 addr", a, 1);
    send(8'hA5, 1'b0, a, v); chk("R6 key0 good", a, 1);
    send(8'h5A, 1'b0, a, v); chk("R6 key1 good", a, 1);
    @(negedge clk) ev_stop = 1;
    @(negedge clk) begin
      ev_stop = 0;
      chk("R8 pulse", srst_pulse, 1);
      set_defaults();
      check_cfg("R9 defaults in pulse cycle");
    end
    @(negedge clk) chk("R8 pulse one cycle", srst_pulse, 0);
    sweep("R9 R2 after reset call");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule